// File: doc/BRIEF.md
# Two-Target Strobed Parallel Display Bus Master

This block sits on the host side of an 8-bit parallel display bus that uses one enable strobe and two chip-select lines, one for each half of a split display controller. A client hands it one operation at a time: a command write, a data write, a status read or a data read, plus the half to address. The block then runs the bus access with every phase measured in system-clock cycles. The cycle counts are derived from nanosecond minimums and the clock period, which are all parameters.

Each command write, data write and data read is preceded by status reads of the addressed half. These repeat while the busy bit of the returned status byte is set. If the controller stays busy for too many polls, the operation is dropped and flagged. A status read request runs as a single access with no polling. Read results come back on a response port together with a one-cycle done pulse.

The data bus appears as a split output, output-enable and input triple, so the pad tri-state sits outside the block.

Top module: `pbus_master`

## Requirements
- R1: Bus encoding. `bus_dsel`=0 addresses command/status and 1 addresses display data. `bus_rd`=1 is a read and 0 is a write. `req_op` codes: 0 command write, 1 data write, 2 status read, 3 data read. `req_tgt`=k asserts only `bus_sel[k]`.
- R2: At most one bit of `bus_sel` is high at any time, and none is high while the block is idle.
- R3: Every access keeps select, `bus_dsel` and `bus_rd` steady for SETUP cycles before `bus_en` rises. It then holds `bus_en` high for HIGH cycles and keeps those lines for HOLD cycles after `bus_en` falls. Consecutive rising edges of `bus_en` are at least CYC cycles apart. Each count is ceil(ns / CLK_NS) with a floor of 1. HIGH is the largest of the high-width count, the write-data-setup count and the read-delay count plus one.
- R4: `bus_oe` is high only during a write access, from the first setup cycle through the last hold cycle. `bus_dout` carries the write byte and does not change while `bus_en` is high or in the following cycle. `bus_oe` is never high while `bus_rd`=1.
- R5: Read data is captured on the last clock of the `bus_en` high window. `rsp_data` returns the captured byte for status and data reads and 0 for writes. `rsp_done` is a single-cycle pulse.
- R6: For ops 0, 1 and 3, the block issues status reads (`bus_dsel`=0, `bus_rd`=1) to the target half until bit 7 of the status byte reads 0, and only then runs the requested access. Op 2 performs exactly one status read.
- R7: If BUSY_LIMIT consecutive polls all return bit 7 = 1, the block pulses `rsp_done` with `rsp_timeout`=1 and `rsp_data`=0, and skips the requested access.
- R8: `req_ready` is high only while no operation is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high, and `req_ready` stays low until that operation completes.
- R9: After synchronous reset: `req_ready`=1, `bus_en`=0, `bus_sel`=0, `bus_oe`=0, `bus_rd`=1, `rsp_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code (see R1) |
| req_tgt | input | $clog2(N_SEL) | Target half index |
| req_data | input | DW | Byte to write |
| rsp_done | output | 1 | Operation finished (one cycle) |
| rsp_data | output | DW | Byte read, 0 for writes |
| rsp_timeout | output | 1 | Busy poll limit hit, with rsp_done |
| bus_dsel | output | 1 | Data (1) / command-status (0) select |
| bus_rd | output | 1 | Read (1) / write (0) |
| bus_en | output | 1 | Enable strobe |
| bus_sel | output | N_SEL | Per-half chip select, active high |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_dout | output | DW | Write byte toward the bus |
| bus_din | input | DW | Byte from the bus |

## Verification
The bench builds the block with CLK_NS=100 and BUSY_LIMIT=3. That gives SETUP=2, HIGH=5, HOLD=1 and a 10-cycle minimum strobe period, so every phase count is short and distinct. It also makes it possible to sweep all four operations over both halves, with the modelled busy run length going from 0 past the poll limit. The bus model counts polls and latches writes on the falling strobe. This exposes the off-by-one boundary between "busy for BUSY_LIMIT-1 polls, then proceed" and "busy for BUSY_LIMIT polls, then time out".

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        OP_CMD_WR  = 2'd0,
        OP_DAT_WR  = 2'd1,
        OP_STAT_RD = 2'd2,
        OP_DAT_RD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD,
        PH_REST
    } phase_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_POLL,
        Q_MAIN
    } seq_e;

    // Whole clock cycles covering ns, never less than one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_strobe.sv
module pbus_strobe
    import pbus_pkg::*;
#(
    parameter int DW        = 8,
    parameter int N_SEL     = 2,
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 5,
    parameter int HOLD_CYC  = 1,
    parameter int REST_CYC  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     acc_dsel,
    input  logic                     acc_rd,
    input  logic [$clog2(N_SEL)-1:0] acc_tgt,
    input  logic [DW-1:0]            acc_wdata,
    output logic                     fin,
    output logic [DW-1:0]            smp,
    output logic                     bus_dsel,
    output logic                     bus_rd,
    output logic                     bus_en,
    output logic [N_SEL-1:0]         bus_sel,
    output logic                     bus_oe,
    output logic [DW-1:0]            bus_dout,
    input  logic [DW-1:0]            bus_din
);
    localparam int TW    = $clog2(N_SEL);
    localparam int MAXC  = imax(imax(SETUP_CYC, HIGH_CYC), imax(HOLD_CYC, REST_CYC));
    localparam int CW    = $clog2(MAXC + 1);

    phase_e          ph;
    logic [CW-1:0]   cnt;
    logic            dsel_q;
    logic            rd_q;
    logic [TW-1:0]   tgt_q;
    logic [DW-1:0]   wd_q;
    logic            drive;
    logic            last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            dsel_q <= 1'b0;
            rd_q   <= 1'b1;
            tgt_q  <= '0;
            wd_q   <= '0;
            smp    <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        dsel_q <= acc_dsel;
                        rd_q   <= acc_rd;
                        tgt_q  <= acc_tgt;
                        wd_q   <= acc_wdata;
                        cnt    <= CW'(SETUP_CYC - 1);
                        ph     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        cnt <= CW'(HIGH_CYC - 1);
                        ph  <= PH_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        smp <= bus_din;
                        cnt <= CW'(HOLD_CYC - 1);
                        ph  <= PH_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        cnt <= CW'(REST_CYC - 1);
                        ph  <= PH_REST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_REST: begin
                    if (last) begin
                        ph <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign drive    = (ph == PH_SETUP) || (ph == PH_HIGH) || (ph == PH_HOLD);
    assign fin      = (ph == PH_REST) && last;
    assign bus_en   = (ph == PH_HIGH);
    assign bus_rd   = drive ? rd_q : 1'b1;
    assign bus_dsel = drive & dsel_q;
    assign bus_oe   = drive & ~rd_q;
    assign bus_dout = bus_oe ? wd_q : '0;

    for (genvar k = 0; k < N_SEL; k++) begin : g_sel
        assign bus_sel[k] = drive && (tgt_q == TW'(k));
    end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DW         = 8,
    parameter int N_SEL      = 2,
    parameter int BUSY_LIMIT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [$clog2(N_SEL)-1:0] req_tgt,
    input  logic [DW-1:0]            req_data,
    output logic                     rsp_done,
    output logic [DW-1:0]            rsp_data,
    output logic                     rsp_timeout,
    output logic                     launch,
    output logic                     acc_dsel,
    output logic                     acc_rd,
    output logic [$clog2(N_SEL)-1:0] acc_tgt,
    output logic [DW-1:0]            acc_wdata,
    input  logic                     fin,
    input  logic [DW-1:0]            smp
);
    localparam int TW       = $clog2(N_SEL);
    localparam int PW       = $clog2(BUSY_LIMIT + 1);
    localparam int BUSY_BIT = DW - 1;

    seq_e          st;
    op_e           op_q;
    logic [TW-1:0] tgt_q;
    logic [DW-1:0] wd_q;
    logic [PW-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= Q_IDLE;
            op_q        <= OP_CMD_WR;
            tgt_q       <= '0;
            wd_q        <= '0;
            polls       <= '0;
            launch      <= 1'b0;
            rsp_done    <= 1'b0;
            rsp_timeout <= 1'b0;
            rsp_data    <= '0;
        end else begin
            launch      <= 1'b0;
            rsp_done    <= 1'b0;
            rsp_timeout <= 1'b0;
            unique case (st)
                Q_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        tgt_q  <= req_tgt;
                        wd_q   <= req_data;
                        polls  <= '0;
                        launch <= 1'b1;
                        st     <= (op_e'(req_op) == OP_STAT_RD) ? Q_MAIN : Q_POLL;
                    end
                end
                Q_POLL: begin
                    if (fin) begin
                        if (smp[BUSY_BIT]) begin
                            if (polls == PW'(BUSY_LIMIT - 1)) begin
                                rsp_done    <= 1'b1;
                                rsp_timeout <= 1'b1;
                                rsp_data    <= '0;
                                st          <= Q_IDLE;
                            end else begin
                                polls  <= polls + 1'b1;
                                launch <= 1'b1;
                            end
                        end else begin
                            launch <= 1'b1;
                            st     <= Q_MAIN;
                        end
                    end
                end
                Q_MAIN: begin
                    if (fin) begin
                        rsp_done <= 1'b1;
                        rsp_data <= acc_rd ? smp : '0;
                        st       <= Q_IDLE;
                    end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

    assign req_ready = (st == Q_IDLE);
    assign acc_rd    = (st == Q_POLL) || (op_q == OP_STAT_RD) || (op_q == OP_DAT_RD);
    assign acc_dsel  = (st == Q_MAIN) && ((op_q == OP_DAT_WR) || (op_q == OP_DAT_RD));
    assign acc_tgt   = tgt_q;
    assign acc_wdata = wd_q;

endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int DW         = 8,
    parameter int N_SEL      = 2,
    parameter int CLK_NS     = 20,
    parameter int T_ASU_NS   = 140,
    parameter int T_AH_NS    = 10,
    parameter int T_HIGH_NS  = 450,
    parameter int T_LOW_NS   = 450,
    parameter int T_CYC_NS   = 1000,
    parameter int T_DSU_NS   = 200,
    parameter int T_RDLY_NS  = 320,
    parameter int BUSY_LIMIT = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [$clog2(N_SEL)-1:0] req_tgt,
    input  logic [DW-1:0]            req_data,
    output logic                     rsp_done,
    output logic [DW-1:0]            rsp_data,
    output logic                     rsp_timeout,
    output logic                     bus_dsel,
    output logic                     bus_rd,
    output logic                     bus_en,
    output logic [N_SEL-1:0]         bus_sel,
    output logic                     bus_oe,
    output logic [DW-1:0]            bus_dout,
    input  logic [DW-1:0]            bus_din
);
    localparam int TW        = $clog2(N_SEL);
    localparam int SETUP_CYC = ns2cyc(T_ASU_NS, CLK_NS);
    localparam int HOLD_CYC  = ns2cyc(T_AH_NS, CLK_NS);
    localparam int HIGH_CYC  = imax(imax(ns2cyc(T_HIGH_NS, CLK_NS), ns2cyc(T_DSU_NS, CLK_NS)),
                                    ns2cyc(T_RDLY_NS, CLK_NS) + 1);
    localparam int LOW_NEED  = imax(ns2cyc(T_LOW_NS, CLK_NS), ns2cyc(T_CYC_NS, CLK_NS) - HIGH_CYC);
    localparam int REST_CYC  = imax(1, LOW_NEED - HOLD_CYC - SETUP_CYC);

    logic          launch;
    logic          acc_dsel;
    logic          acc_rd;
    logic [TW-1:0] acc_tgt;
    logic [DW-1:0] acc_wdata;
    logic          fin;
    logic [DW-1:0] smp;

    pbus_seq #(
        .DW(DW), .N_SEL(N_SEL), .BUSY_LIMIT(BUSY_LIMIT)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_tgt(req_tgt), .req_data(req_data),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
        .launch(launch), .acc_dsel(acc_dsel), .acc_rd(acc_rd),
        .acc_tgt(acc_tgt), .acc_wdata(acc_wdata),
        .fin(fin), .smp(smp)
    );

    pbus_strobe #(
        .DW(DW), .N_SEL(N_SEL), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
        .HOLD_CYC(HOLD_CYC), .REST_CYC(REST_CYC)
    ) u_strobe (
        .clk(clk), .rst(rst), .start(launch),
        .acc_dsel(acc_dsel), .acc_rd(acc_rd), .acc_tgt(acc_tgt), .acc_wdata(acc_wdata),
        .fin(fin), .smp(smp),
        .bus_dsel(bus_dsel), .bus_rd(bus_rd), .bus_en(bus_en), .bus_sel(bus_sel),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
    parameter int DW       = 8,
    parameter int N_SEL    = 2,
    parameter int HIGH_CYC = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             rsp_done,
    input logic             rsp_timeout,
    input logic             bus_dsel,
    input logic             bus_rd,
    input logic             bus_en,
    input logic [N_SEL-1:0] bus_sel,
    input logic             bus_oe,
    input logic [DW-1:0]    bus_dout
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)         hi_cnt <= '0;
        else if (bus_en) hi_cnt <= hi_cnt + 1'b1;
        else             hi_cnt <= '0;
    end

    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_sel));

    a_r2_idle_no_select: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_sel == '0) && !bus_en);

    a_r3_setup_before_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en) |-> $stable({bus_dsel, bus_rd, bus_sel}) && (bus_sel != '0));

    a_r3_hold_after_high: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> $stable({bus_dsel, bus_rd, bus_sel}) && (bus_sel != '0));

    a_r3_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_en) |-> (hi_cnt == 16'(HIGH_CYC)));

    a_r4_oe_only_write: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !bus_rd && (bus_sel != '0));

    a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> $stable(bus_dout) && bus_oe == $past(bus_oe));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        rsp_timeout |-> rsp_done);

endmodule

bind pbus_master pbus_master_chk #(
    .DW(DW), .N_SEL(N_SEL), .HIGH_CYC(HIGH_CYC)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_timeout(rsp_timeout), .bus_dsel(bus_dsel), .bus_rd(bus_rd),
    .bus_en(bus_en), .bus_sel(bus_sel), .bus_oe(bus_oe), .bus_dout(bus_dout)
);

// File: tb/pbus_master_tb.sv
module pbus_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_NS     = 100;
    localparam int LIMIT      = 3;
    localparam int WD_CYCLES  = 150000;

    // Expected phase lengths, worked from the nanosecond minimums.
    localparam int E_SETUP = (140 + CLK_NS - 1) / CLK_NS;
    localparam int E_HOLD  = 1;
    localparam int E_HIGH  = 5;
    localparam int E_CYC   = (1000 + CLK_NS - 1) / CLK_NS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'd0;
    logic [0:0] req_tgt = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       rsp_done;
    logic [7:0] rsp_data;
    logic       rsp_timeout;
    logic       bus_dsel, bus_rd, bus_en, bus_oe;
    logic [1:0] bus_sel;
    logic [7:0] bus_dout;
    logic [7:0] bus_din;

    int checks = 0;
    int errors = 0;

    // Display model state
    int         busy_left [2];
    logic [7:0] rd_val [2];
    int         stat_cnt [2];
    int         wr_cnt, drd_cnt;
    logic       wr_dsel, wr_half;
    logic [7:0] wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_master #(
        .DW(8), .N_SEL(2), .CLK_NS(CLK_NS), .BUSY_LIMIT(LIMIT)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_tgt(req_tgt), .req_data(req_data),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
        .bus_dsel(bus_dsel), .bus_rd(bus_rd), .bus_en(bus_en), .bus_sel(bus_sel),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    logic hsel;
    assign hsel = bus_sel[1];
    assign bus_din = (bus_en && bus_rd && bus_sel != 2'b00)
                   ? (bus_dsel ? rd_val[hsel] : {busy_left[hsel] != 0, 7'h12})
                   : 8'h5A;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus monitor: phase lengths and transfer recording, at the falling clock.
    int         pre = 0, hi = 0, post = 0, cyc = 0, last_rise = -1;
    logic       hi_seen = 1'b0, prev_en = 1'b0;
    logic [1:0] prev_sel = 2'b00;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (bus_sel != 2'b00 && !bus_en && !hi_seen) pre++;
            if (bus_en) begin
                if (!prev_en) begin
                    chk(pre == E_SETUP, "R3 setup cycles", pre, E_SETUP);
                    if (last_rise >= 0)
                        chk(cyc - last_rise >= E_CYC, "R3 strobe period", cyc - last_rise, E_CYC);
                    last_rise = cyc;
                    hi_seen = 1'b1;
                end
                hi++;
            end
            if (!bus_en && prev_en) begin
                chk(hi == E_HIGH, "R3 high cycles", hi, E_HIGH);
                chk(bus_sel == 2'b01 || bus_sel == 2'b10, "R2 single select", bus_sel, 1);
                if (!bus_rd) begin
                    chk(bus_oe == 1'b1, "R4 oe in write hold", bus_oe, 1);
                    wr_cnt++;
                    wr_dsel = bus_dsel;
                    wr_half = bus_sel[1];
                    wr_data = bus_dout;
                end else if (!bus_dsel) begin
                    stat_cnt[bus_sel[1]]++;
                    if (busy_left[bus_sel[1]] > 0) busy_left[bus_sel[1]]--;
                end else begin
                    drd_cnt++;
                end
            end
            if (!bus_en && hi_seen && bus_sel != 2'b00) post++;
            if (bus_sel == 2'b00 && prev_sel != 2'b00) begin
                chk(post == E_HOLD, "R3 hold cycles", post, E_HOLD);
                pre = 0; hi = 0; post = 0; hi_seen = 1'b0;
            end
            prev_en  = bus_en;
            prev_sel = bus_sel;
        end
    end

    task automatic run_op(input logic [1:0] op, input logic h, input logic [7:0] wd,
                          input int busy_n, input logic [7:0] rv);
        logic       exp_to;
        int         exp_polls;
        int         exp_wr;
        int         exp_drd;
        logic [7:0] exp_data;
        busy_left[h] = busy_n;
        busy_left[~h] = 0;
        rd_val[h] = rv;
        rd_val[~h] = ~rv;
        stat_cnt[0] = 0; stat_cnt[1] = 0; wr_cnt = 0; drd_cnt = 0;

        exp_to    = (op != 2'd2) && (busy_n >= LIMIT);
        exp_polls = (op == 2'd2) ? 1 : (exp_to ? LIMIT : busy_n + 1);
        exp_wr    = (op < 2'd2 && !exp_to) ? 1 : 0;
        exp_drd   = (op == 2'd3 && !exp_to) ? 1 : 0;
        exp_data  = (op == 2'd3 && !exp_to) ? rv :
                    (op == 2'd2) ? {busy_n != 0, 7'h12} : 8'h00;

        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_tgt = h; req_data = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
        while (!rsp_done) @(negedge clk);
        chk(rsp_timeout == exp_to, "R7 timeout flag", rsp_timeout, exp_to);
        chk(rsp_data == exp_data, "R5 response data", rsp_data, exp_data);
        chk(stat_cnt[h] == exp_polls, "R6 status reads on target", stat_cnt[h], exp_polls);
        chk(stat_cnt[~h] == 0, "R1 other half untouched", stat_cnt[~h], 0);
        chk(wr_cnt == exp_wr, "R6 write issued", wr_cnt, exp_wr);
        chk(drd_cnt == exp_drd, "R6 data read issued", drd_cnt, exp_drd);
        if (exp_wr == 1) begin
            chk(wr_dsel == op[0], "R1 write dsel", wr_dsel, op[0]);
            chk(wr_half == h, "R1 write target", wr_half, h);
            chk(wr_data == wd, "R4 write byte", wr_data, wd);
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R5 done single cycle", rsp_done, 0);
        chk(req_ready == 1'b1, "R8 ready after done", req_ready, 1);
        chk(bus_sel == 2'b00 && !bus_oe, "R2 idle bus", {bus_sel, bus_oe}, 0);
    endtask

    initial begin
        busy_left[0] = 0; busy_left[1] = 0;
        rd_val[0] = 8'h00; rd_val[1] = 8'h00;
        stat_cnt[0] = 0; stat_cnt[1] = 0;
        wr_cnt = 0; drd_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
        chk(bus_en == 1'b0, "R9 reset strobe", bus_en, 0);
        chk(bus_sel == 2'b00, "R9 reset select", bus_sel, 0);
        chk(bus_oe == 1'b0, "R9 reset oe", bus_oe, 0);
        chk(bus_rd == 1'b1, "R9 reset read level", bus_rd, 1);
        chk(rsp_done == 1'b0, "R9 reset done", rsp_done, 0);

        for (int op = 0; op < 4; op++) begin
            for (int h = 0; h < 2; h++) begin
                for (int b = 0; b <= LIMIT + 1; b++) begin
                    run_op(2'(op), 1'(h), 8'(op * 37 + h * 91 + b * 13 + 1), b,
                           8'(op * 53 + h * 17 + b * 29 + 128));
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", WD_CYCLES);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule